// File: doc/BRIEF.md
# DMA Transfer Timing Sequencer

This block is the per-service state machine of a direct memory access controller. Once a channel has been granted, it requests the system bus, waits for the bus to be granted, and then steps one clock per state through the working states of each transfer. Along the way it drives the upper-address strobe, the address enable, the memory and I/O read/write command strobes and an advance pulse. The advance pulse tells the channel's address and count registers to update.

Each service is shaped by a few settings. The transfer mode decides when the bus is given back. Normal or compressed timing sets how many states a transfer takes. The transfer kind picks which command strobes fire; verify transfers fire none. The surrounding logic supplies a last-count flag from the word counter and a flag that says the upper address byte has changed. It also supplies an external stop request. The sequencer reports the terminal count on a one-cycle done pulse. Transfers between two memory locations are not part of this block.

Top module: `dseq_top`

## Requirements
- R1: While `rst` is high the sequencer is forced to idle, and one cycle after `rst` it shows idle with all outputs low. The state codes are: idle=0, hold-wait=1, upper-address=2, address=3, read-extend=4, transfer=5, wait=6.
- R2: From idle, a high `grant_valid` moves to hold-wait. Hold-wait repeats while `hold_ack` is low and moves to upper-address once it is high. `hold_req` is high in every state except idle.
- R3: The first transfer of a service passes through upper-address, the only state with `hi_addr_stb` high. After a transfer state that does not end the service, the next state is upper-address when `hi_addr_chg` is high, and address otherwise. `addr_en` is high in states 2 through 6.
- R4: With `fast_timing` low, a transfer runs address, read-extend, transfer. If `rdy` is low in read-extend, wait states are inserted, and they continue until `rdy` is sampled high.
- R5: With `fast_timing` high, read-extend is skipped and address leads to transfer. Wait states are placed after address while `rdy` is low.
- R6: Kind 01 (device to memory) drives `io_rd` and `mem_wr`. Kind 10 (memory to device) drives `mem_rd` and `io_wr`. The read strobe is high in read-extend, wait and transfer, and the write strobe in wait and transfer. `adv` is high in every transfer state.
- R7: Kinds 00 and 11 are verify transfers. All four command strobes stay low and `rdy` is ignored, so no wait state occurs.
- R8: Mode 01 (single) returns to idle after each transfer state. A further transfer needs a fresh pass through hold-wait.
- R9: Modes 10 and 11 (block) end the service only on terminal count or an external stop. Mode 00 (demand) also ends when `chan_req_lvl` is low in the transfer state. `last_count` is sampled in the address state.
- R10: `ext_stop` is captured only when the state is not idle. It takes effect at the next address state, ending the service after that transfer, and never drives `done_pulse`.
- R11: When `last_count` is seen, `done_pulse` is high for one cycle. With normal timing this is the final transfer state. With compressed timing it is the final address state.
- R12: After the final transfer state the sequencer enters idle, and `hold_req` and `addr_en` are both low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant_valid | input | 1 | A channel has been granted and wants service |
| chan_req_lvl | input | 1 | Present request level of the granted channel (demand mode) |
| hold_ack | input | 1 | Bus grant from the host |
| rdy | input | 1 | Slow-device ready; low inserts wait states |
| xfer_mode | input | 2 | 00 demand, 01 single, 10/11 block |
| xfer_kind | input | 2 | 00 verify, 01 device-to-memory, 10 memory-to-device, 11 verify |
| fast_timing | input | 1 | Compressed timing select |
| ext_stop | input | 1 | External end-of-process request, active high |
| last_count | input | 1 | Word counter is on its final transfer |
| hi_addr_chg | input | 1 | Upper address byte changed after the last advance |
| seq_state | output | 3 | Current state code |
| hold_req | output | 1 | Bus request to the host |
| addr_en | output | 1 | Address output enable |
| hi_addr_stb | output | 1 | Upper address byte strobe |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command |
| io_rd | output | 1 | I/O read command |
| io_wr | output | 1 | I/O write command |
| adv | output | 1 | Advance address and count |
| done_pulse | output | 1 | Terminal-count end-of-process pulse |

## Verification
Terminal count and an external stop can both land on the same transfer. The bench provokes this by raising `last_count` and pulsing `ext_stop` while the upper-address state is running. Both then reach the address state of the same transfer. The service is judged correct when it ends after exactly that one transfer, drops the bus in the next cycle, and `done_pulse` appears only once, in the transfer state.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  localparam int STATE_W = 3;
  localparam int SEL_W   = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_UADDR = 3'd2,
    ST_ADDR  = 3'd3,
    ST_REXT  = 3'd4,
    ST_XFER  = 3'd5,
    ST_WAIT  = 3'd6
  } seq_state_e;

  localparam logic [SEL_W-1:0] MODE_DEMAND = 2'b00;
  localparam logic [SEL_W-1:0] MODE_SINGLE = 2'b01;

  localparam logic [SEL_W-1:0] KIND_VERIFY = 2'b00;
  localparam logic [SEL_W-1:0] KIND_DEV2MEM = 2'b01;
  localparam logic [SEL_W-1:0] KIND_MEM2DEV = 2'b10;
  localparam logic [SEL_W-1:0] KIND_VERIFY2 = 2'b11;

  function automatic logic is_verify(input logic [SEL_W-1:0] kind);
    return (kind == KIND_VERIFY) || (kind == KIND_VERIFY2);
  endfunction

endpackage

// File: rtl/dseq_stop_latch.sv
module dseq_stop_latch (
  input  logic clk,
  input  logic rst,
  input  logic in_idle,
  input  logic ext_stop,
  output logic pend
);
  // Holds an external stop request until the service returns to idle.
  always_ff @(posedge clk) begin
    if (rst || in_idle) pend <= 1'b0;
    else if (ext_stop)  pend <= 1'b1;
  end
endmodule

// File: rtl/dseq_fsm.sv
module dseq_fsm
  import dseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             grant_valid,
  input  logic             chan_req_lvl,
  input  logic             hold_ack,
  input  logic             rdy,
  input  logic [SEL_W-1:0] xfer_mode,
  input  logic [SEL_W-1:0] xfer_kind,
  input  logic             fast_timing,
  input  logic             last_count,
  input  logic             hi_addr_chg,
  input  logic             stop_pend,
  output seq_state_e       st,
  output logic             tc_seen
);
  seq_state_e st_nx;
  logic       stop_seen;
  logic       go_on;
  logic       finish;

  // Ready is disregarded for verify transfers.
  assign go_on  = rdy || is_verify(xfer_kind);

  assign finish = tc_seen || stop_seen ||
                  (xfer_mode == MODE_SINGLE) ||
                  ((xfer_mode == MODE_DEMAND) && !chan_req_lvl);

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  st_nx = grant_valid ? ST_HOLD : ST_IDLE;
      ST_HOLD:  st_nx = hold_ack ? ST_UADDR : ST_HOLD;
      ST_UADDR: st_nx = ST_ADDR;
      ST_ADDR:  begin
        if (!fast_timing) st_nx = ST_REXT;
        else              st_nx = go_on ? ST_XFER : ST_WAIT;
      end
      ST_REXT:  st_nx = go_on ? ST_XFER : ST_WAIT;
      ST_WAIT:  st_nx = go_on ? ST_XFER : ST_WAIT;
      ST_XFER:  begin
        if (finish)           st_nx = ST_IDLE;
        else if (hi_addr_chg) st_nx = ST_UADDR;
        else                  st_nx = ST_ADDR;
      end
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nx;
  end

  // End conditions are sampled once per transfer, in the address state.
  always_ff @(posedge clk) begin
    if (rst || st == ST_IDLE) begin
      tc_seen   <= 1'b0;
      stop_seen <= 1'b0;
    end else if (st == ST_ADDR) begin
      tc_seen   <= last_count;
      stop_seen <= stop_pend;
    end
  end
endmodule

// File: rtl/dseq_decode.sv
module dseq_decode
  import dseq_pkg::*;
(
  input  seq_state_e       st,
  input  logic [SEL_W-1:0] xfer_kind,
  input  logic             fast_timing,
  input  logic             last_count,
  input  logic             tc_seen,
  output logic             hold_req,
  output logic             addr_en,
  output logic             hi_addr_stb,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             io_rd,
  output logic             io_wr,
  output logic             adv,
  output logic             done_pulse
);
  logic rd_on;
  logic wr_on;

  always_comb begin
    hold_req    = (st != ST_IDLE);
    addr_en     = (st != ST_IDLE) && (st != ST_HOLD);
    hi_addr_stb = (st == ST_UADDR);
    rd_on       = !is_verify(xfer_kind) &&
                  ((st == ST_REXT) || (st == ST_WAIT) || (st == ST_XFER));
    wr_on       = !is_verify(xfer_kind) &&
                  ((st == ST_WAIT) || (st == ST_XFER));
    io_rd       = rd_on && (xfer_kind == KIND_DEV2MEM);
    mem_wr      = wr_on && (xfer_kind == KIND_DEV2MEM);
    mem_rd      = rd_on && (xfer_kind == KIND_MEM2DEV);
    io_wr       = wr_on && (xfer_kind == KIND_MEM2DEV);
    adv         = (st == ST_XFER);
    done_pulse  = (fast_timing  && (st == ST_ADDR) && last_count) ||
                  (!fast_timing && (st == ST_XFER) && tc_seen);
  end
endmodule

// File: rtl/dseq_top.sv
module dseq_top
  import dseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               grant_valid,
  input  logic               chan_req_lvl,
  input  logic               hold_ack,
  input  logic               rdy,
  input  logic [SEL_W-1:0]   xfer_mode,
  input  logic [SEL_W-1:0]   xfer_kind,
  input  logic               fast_timing,
  input  logic               ext_stop,
  input  logic               last_count,
  input  logic               hi_addr_chg,
  output logic [STATE_W-1:0] seq_state,
  output logic               hold_req,
  output logic               addr_en,
  output logic               hi_addr_stb,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic               io_rd,
  output logic               io_wr,
  output logic               adv,
  output logic               done_pulse
);
  seq_state_e st;
  logic       stop_pend;
  logic       tc_seen;

  dseq_stop_latch u_stop (
    .clk      (clk),
    .rst      (rst),
    .in_idle  (st == ST_IDLE),
    .ext_stop (ext_stop),
    .pend     (stop_pend)
  );

  dseq_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .grant_valid  (grant_valid),
    .chan_req_lvl (chan_req_lvl),
    .hold_ack     (hold_ack),
    .rdy          (rdy),
    .xfer_mode    (xfer_mode),
    .xfer_kind    (xfer_kind),
    .fast_timing  (fast_timing),
    .last_count   (last_count),
    .hi_addr_chg  (hi_addr_chg),
    .stop_pend    (stop_pend),
    .st           (st),
    .tc_seen      (tc_seen)
  );

  dseq_decode u_dec (
    .st          (st),
    .xfer_kind   (xfer_kind),
    .fast_timing (fast_timing),
    .last_count  (last_count),
    .tc_seen     (tc_seen),
    .hold_req    (hold_req),
    .addr_en     (addr_en),
    .hi_addr_stb (hi_addr_stb),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .io_rd       (io_rd),
    .io_wr       (io_wr),
    .adv         (adv),
    .done_pulse  (done_pulse)
  );

  assign seq_state = st;
endmodule

// File: rtl/dseq_chk.sv
module dseq_chk
  import dseq_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               hold_ack,
  input logic               rdy,
  input logic [SEL_W-1:0]   xfer_mode,
  input logic [SEL_W-1:0]   xfer_kind,
  input logic               fast_timing,
  input logic [STATE_W-1:0] seq_state,
  input logic               hold_req,
  input logic               addr_en,
  input logic               mem_rd,
  input logic               mem_wr,
  input logic               io_rd,
  input logic               io_wr,
  input logic               done_pulse
);
  logic ver;
  assign ver = (xfer_kind == KIND_VERIFY) || (xfer_kind == KIND_VERIFY2);

  // R2
  hold_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_state == ST_HOLD && !hold_ack) |=> seq_state == ST_HOLD);

  // R3
  uaddr_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_state == ST_UADDR) |->
      ($past(seq_state) == ST_HOLD || $past(seq_state) == ST_XFER));

  // R4
  wait_insert_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_state == ST_REXT && !rdy && !ver) |=> seq_state == ST_WAIT);

  // R5
  no_rext_chk: assert property (@(posedge clk) disable iff (rst)
    (fast_timing && seq_state == ST_ADDR) |=> seq_state != ST_REXT);

  // R7
  verify_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ver |-> !(mem_rd || mem_wr || io_rd || io_wr));

  // R8
  single_release_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_mode == MODE_SINGLE && seq_state == ST_XFER) |=> seq_state == ST_IDLE);

  // R11
  done_place_chk: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> ((!fast_timing && seq_state == ST_XFER) ||
                    (fast_timing && seq_state == ST_ADDR)));

  // R12
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_state == ST_IDLE && $past(seq_state) == ST_XFER) |-> (!hold_req && !addr_en));
endmodule

bind dseq_top dseq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .hold_ack    (hold_ack),
  .rdy         (rdy),
  .xfer_mode   (xfer_mode),
  .xfer_kind   (xfer_kind),
  .fast_timing (fast_timing),
  .seq_state   (seq_state),
  .hold_req    (hold_req),
  .addr_en     (addr_en),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .io_rd       (io_rd),
  .io_wr       (io_wr),
  .done_pulse  (done_pulse)
);

// File: tb/tb_dseq_top.sv
module tb_dseq_top;
  localparam logic [2:0] I = 3'd0, H = 3'd1, U = 3'd2, A = 3'd3,
                         R = 3'd4, X = 3'd5, W = 3'd6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic grant_valid = 0, chan_req_lvl = 0, hold_ack = 0, rdy = 1;
  logic [1:0] xfer_mode = 2'b10, xfer_kind = 2'b01;
  logic fast_timing = 0, ext_stop = 0, last_count = 0, hi_addr_chg = 0;
  logic [2:0] seq_state;
  logic hold_req, addr_en, hi_addr_stb, mem_rd, mem_wr, io_rd, io_wr, adv, done_pulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  dseq_top dut (
    .clk(clk), .rst(rst), .grant_valid(grant_valid), .chan_req_lvl(chan_req_lvl),
    .hold_ack(hold_ack), .rdy(rdy), .xfer_mode(xfer_mode), .xfer_kind(xfer_kind),
    .fast_timing(fast_timing), .ext_stop(ext_stop), .last_count(last_count),
    .hi_addr_chg(hi_addr_chg), .seq_state(seq_state), .hold_req(hold_req),
    .addr_en(addr_en), .hi_addr_stb(hi_addr_stb), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_rd(io_rd), .io_wr(io_wr), .adv(adv), .done_pulse(done_pulse)
  );

  // Expected output vector {state, hold, aen, stb, mrd, mwr, ird, iwr, adv, done}
  function automatic logic [11:0] expect_vec(input logic [2:0] st, input logic dn,
                                             input logic [1:0] kind);
    logic rd, wr, vf;
    vf = (kind == 2'b00) || (kind == 2'b11);
    rd = !vf && (st == R || st == W || st == X);
    wr = !vf && (st == W || st == X);
    return {st, st != I, (st != I && st != H), st == U,
            rd && kind == 2'b10, wr && kind == 2'b01,
            rd && kind == 2'b01, wr && kind == 2'b10, st == X, dn};
  endfunction

  // Scoreboard monitor: compares one expected item per cycle after each edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [3:0]  e;
      string       t;
      logic [11:0] ex, ac;
      e  = exp_q.pop_front();
      t  = tag_q.pop_front();
      ex = expect_vec(e[2:0], e[3], xfer_kind);
      ac = {seq_state, hold_req, addr_en, hi_addr_stb, mem_rd, mem_wr,
            io_rd, io_wr, adv, done_pulse};
      checks++;
      if (ac !== ex) begin
        errors++;
        $display("FAIL %s actual=%b expected=%b", t, ac, ex);
      end
    end
  end

  // Driver: push the outcome of the coming edge, then move to the next falling edge.
  task automatic nxt(input logic [2:0] st, input logic dn, input string tag);
    exp_q.push_back({dn, st});
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 3000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected<3000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({seq_state, hold_req, addr_en, hi_addr_stb, mem_rd, mem_wr, io_rd, io_wr,
         adv, done_pulse} !== 12'd0) begin
      errors++;
      $display("FAIL R1 actual=%b expected=0", seq_state);
    end
    rst = 1'b0;
    nxt(I, 0, "R1 idle after reset");

    // Normal block, device to memory, waits, terminal count (R2 R4 R6 R9 R11 R12)
    grant_valid = 1;
    nxt(H, 0, "R2 hold request");
    nxt(H, 0, "R2 hold repeats");
    hold_ack = 1;
    nxt(U, 0, "R3 first upper address");
    nxt(A, 0, "R4 address");
    nxt(R, 0, "R4 read extend");
    rdy = 0;
    nxt(W, 0, "R4 wait inserted");
    nxt(W, 0, "R4 wait held");
    rdy = 1;
    nxt(X, 0, "R6 transfer strobes");
    nxt(A, 0, "R3 no upper change");
    last_count = 1;
    nxt(R, 0, "R9 tc sampled");
    nxt(X, 1, "R11 done in transfer");
    grant_valid = 0;
    nxt(I, 0, "R12 release after tc");
    last_count = 0; hold_ack = 0;
    nxt(I, 0, "R12 stays idle");

    // Compressed, memory to device, upper change, wait after address (R3 R5 R11)
    xfer_kind = 2'b10; fast_timing = 1; grant_valid = 1;
    nxt(H, 0, "R2 hold request");
    hold_ack = 1;
    nxt(U, 0, "R3 upper address");
    nxt(A, 0, "R5 address");
    rdy = 0;
    nxt(W, 0, "R5 wait after address");
    rdy = 1;
    nxt(X, 0, "R6 read type strobes");
    hi_addr_chg = 1;
    nxt(U, 0, "R3 upper address on change");
    hi_addr_chg = 0; last_count = 1;
    nxt(A, 1, "R11 compressed done in address");
    nxt(X, 0, "R5 no read extend");
    grant_valid = 0;
    nxt(I, 0, "R12 release compressed");
    last_count = 0; hold_ack = 0; fast_timing = 0;
    nxt(I, 0, "R12 idle");

    // Verify with ready low (R7)
    xfer_kind = 2'b00; rdy = 0; grant_valid = 1; hold_ack = 1;
    nxt(H, 0, "R7 hold");
    nxt(U, 0, "R7 upper");
    nxt(A, 0, "R7 address");
    nxt(R, 0, "R7 read extend quiet");
    nxt(X, 0, "R7 ready ignored");
    nxt(A, 0, "R7 second transfer");
    last_count = 1;
    nxt(R, 0, "R7 quiet");
    nxt(X, 1, "R7 verify still counts");
    grant_valid = 0;
    nxt(I, 0, "R7 end");
    last_count = 0; rdy = 1; hold_ack = 0;

    // Single mode (R8)
    xfer_kind = 2'b01; xfer_mode = 2'b01; grant_valid = 1; hold_ack = 1;
    nxt(H, 0, "R8 hold");
    nxt(U, 0, "R8 upper");
    nxt(A, 0, "R8 address");
    nxt(R, 0, "R8 read extend");
    nxt(X, 0, "R8 transfer");
    nxt(I, 0, "R8 bus released");
    nxt(H, 0, "R8 fresh hold");
    nxt(U, 0, "R8 new service upper");
    nxt(A, 0, "R8 address");
    nxt(R, 0, "R8 read extend");
    grant_valid = 0;
    nxt(X, 0, "R8 transfer");
    nxt(I, 0, "R8 released again");
    hold_ack = 0;

    // Demand mode, request drops (R9)
    xfer_mode = 2'b00; grant_valid = 1; chan_req_lvl = 1; hold_ack = 1;
    nxt(H, 0, "R9 hold");
    nxt(U, 0, "R9 upper");
    nxt(A, 0, "R9 address");
    nxt(R, 0, "R9 read extend");
    nxt(X, 0, "R9 transfer");
    nxt(A, 0, "R9 demand continues");
    nxt(R, 0, "R9 read extend");
    chan_req_lvl = 0; grant_valid = 0;
    nxt(X, 0, "R9 transfer");
    nxt(I, 0, "R9 demand request dropped");
    hold_ack = 0;

    // External stop: ignored in idle, acted on at next address (R10)
    xfer_mode = 2'b10; ext_stop = 1;
    nxt(I, 0, "R10 idle stop");
    ext_stop = 0; grant_valid = 1; hold_ack = 1;
    nxt(H, 0, "R10 hold");
    nxt(U, 0, "R10 upper");
    nxt(A, 0, "R10 address");
    nxt(R, 0, "R10 read extend");
    ext_stop = 1;
    nxt(X, 0, "R10 transfer");
    ext_stop = 0;
    nxt(A, 0, "R10 idle stop was ignored");
    nxt(R, 0, "R10 read extend");
    grant_valid = 0;
    nxt(X, 0, "R10 no done for external stop");
    nxt(I, 0, "R10 stop ends service");
    hold_ack = 0;

    // Terminal count and external stop on the same transfer (R9 R10 R11)
    grant_valid = 1; hold_ack = 1;
    nxt(H, 0, "R9 hold");
    nxt(U, 0, "R9 upper");
    ext_stop = 1; last_count = 1;
    nxt(A, 0, "R10 both pending");
    ext_stop = 0;
    nxt(R, 0, "R9 read extend");
    grant_valid = 0;
    nxt(X, 1, "R11 single done pulse");
    last_count = 0;
    nxt(I, 0, "R12 joint end");
    nxt(I, 0, "R11 no second pulse");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule